// File: doc/BRIEF.md
# Single-Shot Transmit Error Injector

This block sits in a T1/E1 transmit path and inserts single deliberate errors for line testing. On the binary side it takes one data bit per cycle, with two marker inputs that flag frame-bit and CRC-bit positions. When a frame-bit or CRC error has been requested, it inverts the next bit that carries the matching marker. On the line side it takes the dual-rail pulse pair from the line encoder. When a line-code error has been requested, it inserts a bipolar violation: one in T1 mode, or two same-polarity violations in a row in E1 HDB3 mode.

Requests arrive as one-cycle pulses. Each request is held in a pending flag until it has been applied. A request that arrives while the same kind is already pending is absorbed into the pending one. After a violation the injector swaps the rail of every later mark, so that the marks that follow keep alternating relative to the forced mark. All outputs are registered and appear one cycle after the inputs they come from.

Top module: `txerr_inject`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `bit_out`, `rail_p_out`, `rail_n_out` and the three busy flags are all 0.
- R2: When no binary error is pending for a marked position, `bit_out` equals the `bit_in` of the previous cycle.
- R3: A `req_frame` pulse makes `busy_frame` go high on the next cycle. The next input bit with `at_frame`=1 that arrives while `busy_frame` is high is inverted at `bit_out`, and `busy_frame` drops after that bit. Exactly one bit is inverted.
- R4: `req_crc` behaves as R3 does, but it uses `at_crc` and `busy_crc`.
- R5: A request that arrives while the same kind of request is pending, including in the cycle it is applied, causes no extra error.
- R6: Frame, CRC and line-code requests are independent, and any of them may be pending together. A bit marked both frame and CRC, with both pending, is inverted twice, so it is passed unchanged.
- R7: With `e1_hdb3`=0 when it is requested, a line-code error puts the next input mark (`rail_p_in` or `rail_n_in` high) on the same output rail as the previous output mark. `busy_line` stays high until that mark.
- R8: With `e1_hdb3`=1 when it is requested, the next two input marks are both put on the rail of the output mark that precedes them.
- R9: Request inputs held at 0 have no effect on any output.
- R10: A space (both rail inputs 0) gives a space at the outputs. The output rails are never both high. Once no violation is pending, each mark keeps its input rail, XORed with a swap state that the last injected violation set.
- R11: A request that arrives in the same cycle as an eligible bit or mark does not apply to that bit. It applies to the next eligible one.
- R12: After reset the swap state is cleared, and the previous output mark counts as negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e1_hdb3 | input | 1 | 1: E1 HDB3 double violation; 0: T1 single violation (sampled with `req_line`) |
| req_frame | input | 1 | Frame-bit error request pulse |
| req_crc | input | 1 | CRC-bit error request pulse |
| req_line | input | 1 | Line-code error request pulse |
| bit_in | input | 1 | Binary transmit bit |
| at_frame | input | 1 | `bit_in` is a frame bit |
| at_crc | input | 1 | `bit_in` is a CRC bit |
| rail_p_in | input | 1 | Positive pulse from the encoder |
| rail_n_in | input | 1 | Negative pulse from the encoder |
| bit_out | output | 1 | Binary bit after injection |
| rail_p_out | output | 1 | Positive pulse after injection |
| rail_n_out | output | 1 | Negative pulse after injection |
| busy_frame | output | 1 | Frame-bit error pending |
| busy_crc | output | 1 | CRC-bit error pending |
| busy_line | output | 1 | Line-code error pending |

## Verification
Every output is due exactly one clock after the inputs that cause it. This includes the inverted bit, the forced rail, and the rise and fall of each busy flag. The bench drives a cycle's inputs on the falling edge and compares all six outputs just after the next rising edge against a model that it steps once for each cycle. Requests are swept across every offset against the frame and CRC marker grid, in all combinations and in both modes. A second request is placed three cycles later, so that the cases of an absorbed request and of a request coinciding with a marker fall at known cycles.

// File: rtl/txerr_inject.sv
module txerr_inject #(
  parameter int T1_VIOLS = 1,
  parameter int E1_VIOLS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic e1_hdb3,
  input  logic req_frame,
  input  logic req_crc,
  input  logic req_line,
  input  logic bit_in,
  input  logic at_frame,
  input  logic at_crc,
  input  logic rail_p_in,
  input  logic rail_n_in,
  output logic bit_out,
  output logic rail_p_out,
  output logic rail_n_out,
  output logic busy_frame,
  output logic busy_crc,
  output logic busy_line
);
  localparam int MAXV = (E1_VIOLS > T1_VIOLS) ? E1_VIOLS : T1_VIOLS;
  localparam int CW   = $clog2(MAXV + 1);

  logic [CW-1:0] left;
  logic last_pos, swap;

  wire mark    = rail_p_in | rail_n_in;
  wire force_v = mark & busy_line;
  wire pos_sel = force_v ? last_pos : (rail_p_in ^ swap);

  assign busy_line = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_out    <= 1'b0;
      rail_p_out <= 1'b0;
      rail_n_out <= 1'b0;
      busy_frame <= 1'b0;
      busy_crc   <= 1'b0;
      left       <= '0;
      last_pos   <= 1'b0;
      swap       <= 1'b0;
    end else begin
      bit_out    <= bit_in ^ (busy_frame & at_frame) ^ (busy_crc & at_crc);
      busy_frame <= busy_frame ? ~at_frame : req_frame;
      busy_crc   <= busy_crc   ? ~at_crc   : req_crc;
      rail_p_out <= mark & pos_sel;
      rail_n_out <= mark & ~pos_sel;
      if (mark) last_pos <= pos_sel;
      if (force_v) begin
        swap <= rail_p_in ^ last_pos;
        left <= left - 1'b1;
      end else if (!busy_line && req_line) begin
        left <= e1_hdb3 ? CW'(E1_VIOLS) : CW'(T1_VIOLS);
      end
    end
  end

  assert_rails_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rail_p_out, rail_n_out}));
  assert_space_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mark |=> (!rail_p_out && !rail_n_out));
  assert_idle_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_frame && !busy_crc) |=> (bit_out == $past(bit_in)));
  assert_frame_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_frame && !busy_frame) |=> busy_frame);
  assert_frame_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_frame && at_frame && !(busy_crc && at_crc)) |=> (bit_out != $past(bit_in)));
  assert_frame_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_frame && at_frame) |=> !busy_frame);
  assert_crc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_crc && at_crc) |=> !busy_crc);
  assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_line && !mark) |=> busy_line);
  assert_forced_same_rail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_line && mark) |=> (rail_p_out == $past(last_pos)));
endmodule

// File: tb/test_txerr_inject.sv
module test_txerr_inject;
  logic clk = 0, rst_n = 0;
  logic e1_hdb3 = 0, req_frame = 0, req_crc = 0, req_line = 0;
  logic bit_in = 0, at_frame = 0, at_crc = 0, rail_p_in = 0, rail_n_in = 0;
  logic bit_out, rail_p_out, rail_n_out, busy_frame, busy_crc, busy_line;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  txerr_inject i_txerr_inject (.*);

  // bench model state
  bit mfp, mcp, mlast, mswap;
  int mleft;
  bit enc_pos;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit b, input bit fr, input bit cr, input bit lp, input bit ln,
                     input bit rf, input bit rc, input bit rl, input bit e1);
    bit eb, ep, en, mk, op, forced;
    string btag, rtag;
    @(negedge clk);
    bit_in = b; at_frame = fr; at_crc = cr; rail_p_in = lp; rail_n_in = ln;
    req_frame = rf; req_crc = rc; req_line = rl; e1_hdb3 = e1;
    eb = b ^ (mfp & fr) ^ (mcp & cr);
    btag = (mfp & fr) ? "R3" : ((mcp & cr) ? "R4" : "R2");
    mk = lp | ln;
    forced = mk && (mleft > 0);
    op = forced ? mlast : (lp ^ mswap);
    rtag = forced ? (e1 ? "R8" : "R7") : "R10";
    ep = mk & op; en = mk & ~op;
    if (mk) mlast = op;
    if (forced) begin mswap = lp ^ mlast; mleft--; end
    else if (mleft == 0 && rl) mleft = e1 ? 2 : 1;
    mfp = mfp ? !fr : rf;
    mcp = mcp ? !cr : rc;
    @(posedge clk); #1;
    chk(btag, bit_out, eb);
    chk(rtag, rail_p_out, ep);
    chk(rtag, rail_n_out, en);
    chk("R3", busy_frame, mfp);
    chk("R4", busy_crc, mcp);
    chk("R7", busy_line, mleft > 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, R12 reset polarity state
    chk("R1", bit_out, 0); chk("R1", rail_p_out, 0); chk("R1", rail_n_out, 0);
    chk("R1", busy_frame, 0); chk("R1", busy_crc, 0); chk("R1", busy_line, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1", busy_line, 0); chk("R1", rail_p_out, 0);
    mfp = 0; mcp = 0; mlast = 0; mswap = 0; mleft = 0; enc_pos = 0;
    // R12: a forced first mark goes negative, since last mark counts as negative
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R12", rail_n_out, 1);
    // sweep: mode x request combination x offset (R9 for combo 0; merge R5 via second
    // request at offset+3; coincidence R11 when offset hits a marker; concurrency R6)
    for (int mode = 0; mode < 2; mode++)
      for (int combo = 0; combo < 8; combo++)
        for (int ph = 0; ph < 12; ph++)
          for (int t = 0; t < 24; t++) begin
            bit rq, mk, b;
            rq = (t == ph) || (t == ph + 3);
            mk = ($urandom % 2) == 1;
            b  = ($urandom % 2) == 1;
            if (mk) enc_pos = ~enc_pos;
            cyc(b, (t % 8) == 5, ((t % 6) == 2) || (t == 13),
                mk & enc_pos, mk & ~enc_pos,
                rq & combo[0], rq & combo[1], rq & combo[2], mode[0]);
          end
    // drain any pending line request
    for (int t = 0; t < 8; t++) begin
      enc_pos = ~enc_pos;
      cyc(0, 0, 0, enc_pos, ~enc_pos, 0, 0, 0, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule